// File: doc/BRIEF.md
# Mode-Width Lookup Table Memory

This block is a lookup-table RAM that sits between a host configuration port and a streaming core. The host always moves whole 32-bit words at a word index. The core reads entries whose width is set by a 2-bit mode register: one, two or four bytes. The same physical storage therefore looks like an array of bytes, of halfwords or of words, depending on the mode currently programmed. A core entry is always returned zero-extended to 32 bits.

There are two directions, transmit and receive. Each has its own table and its own mode register. The host selects a direction for every write, read and mode update. Each direction has its own core read port, and both core ports run at the same time. Core reads are registered. The mode and the entry index take effect in the cycle the index is presented.

Top module: `mwlut_mem`

## Requirements
- R1: A host write with `host_we` high stores `host_wdata` into word `host_idx mod DEPTH` of the table picked by `host_dir` (0 = transmit, 1 = receive). Every cycle, `host_rdata` shows the word at `host_idx` of table `host_dir` as sampled one clock earlier.
- R2: Each direction has a 2-bit mode register that resets to 0. A cycle with `mode_we` high loads `mode_wdata` into the register of direction `host_dir`, and the value reads back on `mode_rd[dir]` from the next cycle on.
- R3: With mode code 0 (byte entries), core entry n is bits [8k+7:8k] of word n/4, where k = n mod 4 (little-endian). Bits 31:8 of the result are zero.
- R4: With mode code 1 (halfword entries), core entry n is bits [16k+15:16k] of word n/2, where k = n mod 2. Bits 31:16 of the result are zero.
- R5: With mode code 2 (word entries), core entry n is word n.
- R6: Mode code 3 is reserved and behaves exactly like code 2.
- R7: `core_data[dir]` carries the entry for the index presented on `core_idx[dir]` one clock earlier. It is decoded with the mode that was in force in that earlier cycle, so a mode write in the same cycle affects only later reads.
- R8: When a host write and a core read hit the same word in the same cycle, the core receives the old contents. A read in the following cycle sees the new word.
- R9: The two directions are independent. A write or mode change for one direction leaves the other direction's words, mode and core results unchanged.
- R10: The 11-bit core index is converted to a word address, and that address wraps modulo `DEPTH`. With the default depth of 512, a word-mode index of 600 reads word 88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_dir | input | 1 | Host direction select (0 transmit, 1 receive) |
| host_idx | input | 11 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 32 | Host read data, one cycle after index |
| mode_we | input | 1 | Mode register write strobe for direction `host_dir` |
| mode_wdata | input | 2 | New mode code (0 byte, 1 halfword, 2 word, 3 reserved as word) |
| mode_rd | output | 2x2 | Mode readback, one field per direction |
| core_idx | input | 2x11 | Core entry index, one per direction |
| core_data | output | 2x32 | Zero-extended core entry, one cycle after index |

## Verification
Two collisions can fall in one cycle. The first is a host write together with a core read of the same word. The second is a mode write together with a core read on that direction. The bench drives both pairs in a single cycle. For the first pair it expects the pre-write word and then, one cycle later, the post-write word. For the second pair it expects the entry decoded with the old mode, and the next read decoded with the new mode. A scoreboard fills in expected values from a bench-side word model at the moment each stimulus is applied, so any forwarding or early mode switch shows up as a mismatch.

// File: rtl/mwlut_pkg.sv
package mwlut_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 11;

    typedef enum logic [1:0] {
        EW_BYTE = 2'd0,
        EW_HALF = 2'd1,
        EW_WORD = 2'd2,
        EW_RSVD = 2'd3
    } ewidth_e;

    // captured along with a core read so extraction uses request-time mode
    typedef struct packed {
        ewidth_e    mode;
        logic [1:0] lane;
    } pick_t;

    function automatic logic [IDX_W-1:0] word_of(ewidth_e m, logic [IDX_W-1:0] idx);
        case (m)
            EW_BYTE: return idx >> 2;
            EW_HALF: return idx >> 1;
            default: return idx;
        endcase
    endfunction

    function automatic pick_t pick_of(ewidth_e m, logic [IDX_W-1:0] idx);
        pick_t p;
        p.mode = m;
        case (m)
            EW_BYTE: p.lane = idx[1:0];
            EW_HALF: p.lane = {1'b0, idx[0]};
            default: p.lane = 2'b00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mwlut_bank.sv
module mwlut_bank
    import mwlut_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [WORD_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] rb_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    // both reads registered; a colliding write lands after the read samples
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        ra_data <= mem[ra_addr];
        rb_data <= mem[rb_addr];
    end

endmodule

// File: rtl/mwlut_slice.sv
module mwlut_slice
    import mwlut_pkg::*;
(
    input  pick_t             pick,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] data
);

    always_comb begin
        case (pick.mode)
            EW_BYTE: data = {24'b0, word[{pick.lane, 3'b000} +: 8]};
            EW_HALF: data = {16'b0, word[{pick.lane[0], 4'b0000} +: 16]};
            default: data = word;
        endcase
    end

endmodule

// File: rtl/mwlut_lane.sv
module mwlut_lane
    import mwlut_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_word,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_rd,
    input  logic [IDX_W-1:0]  core_idx,
    output logic [WORD_W-1:0] core_data
);

    ewidth_e           mode_q;
    pick_t             pick_q;
    logic [WORD_W-1:0] raw_q;
    logic [ADDR_W-1:0] host_wa;
    logic [ADDR_W-1:0] core_wa;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= EW_BYTE;
        else if (mode_we) mode_q <= ewidth_e'(mode_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_of(mode_q, core_idx);
    end

    assign host_wa = ADDR_W'(host_idx);
    assign core_wa = ADDR_W'(word_of(mode_q, core_idx));
    assign mode_rd = mode_q;

    mwlut_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .we      (host_we),
        .waddr   (host_wa),
        .wdata   (host_wdata),
        .ra_addr (host_wa),
        .ra_data (host_word),
        .rb_addr (core_wa),
        .rb_data (raw_q)
    );

    mwlut_slice u_slice (
        .pick (pick_q),
        .word (raw_q),
        .data (core_data)
    );

    p_mode_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode_rd == 2'd0);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_rd));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (rst)
        pick_q.mode == EW_BYTE |-> core_data[31:8] == 24'd0);

    p_half_zext_r4: assert property (@(posedge clk) disable iff (rst)
        pick_q.mode == EW_HALF |-> core_data[31:16] == 16'd0);

endmodule

// File: rtl/mwlut_mem.sv
module mwlut_mem
    import mwlut_pkg::*;
#(
    parameter int NUM_DIR = 2,
    parameter int DEPTH   = 512
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            host_dir,
    input  logic [IDX_W-1:0]                host_idx,
    input  logic [WORD_W-1:0]               host_wdata,
    input  logic                            host_we,
    output logic [WORD_W-1:0]               host_rdata,
    input  logic                            mode_we,
    input  logic [1:0]                      mode_wdata,
    output logic [NUM_DIR-1:0][1:0]         mode_rd,
    input  logic [NUM_DIR-1:0][IDX_W-1:0]   core_idx,
    output logic [NUM_DIR-1:0][WORD_W-1:0]  core_data
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic [NUM_DIR-1:0][WORD_W-1:0] host_word;
    logic                           dir_q;

    always_ff @(posedge clk) begin
        if (rst) dir_q <= 1'b0;
        else     dir_q <= host_dir;
    end

    assign host_rdata = host_word[dir_q];

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
        logic sel;
        assign sel = (32'(host_dir) == d);

        mwlut_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .host_we    (host_we & sel),
            .host_idx   (host_idx),
            .host_wdata (host_wdata),
            .host_word  (host_word[d]),
            .mode_we    (mode_we & sel),
            .mode_wdata (mode_wdata),
            .mode_rd    (mode_rd[d]),
            .core_idx   (core_idx[d]),
            .core_data  (core_data[d])
        );
    end

endmodule

// File: tb/mwlut_mem_tb.sv
`timescale 1ns/1ps
module mwlut_mem_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_dir = 1'b0;
    logic [10:0]       host_idx = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_we = 1'b0;
    logic [31:0]       host_rdata;
    logic              mode_we = 1'b0;
    logic [1:0]        mode_wdata = '0;
    logic [1:0][1:0]   mode_rd;
    logic [1:0][10:0]  core_idx = '0;
    logic [1:0][31:0]  core_data;

    always #2.5 clk = ~clk;

    mwlut_mem u_dut (
        .clk(clk), .rst(rst), .host_dir(host_dir), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rd(mode_rd),
        .core_idx(core_idx), .core_data(core_data)
    );

    typedef struct {
        int          kind;   // 0/1 core port of that direction, 2 host
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t       sb[$];
    item_t       it;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [31:0] model [2][512];
    int          bmode [2];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            logic [31:0] act;
            it = sb.pop_front();
            act = (it.kind == 2) ? host_rdata : core_data[it.kind];
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] entry(int d, int idx, int m);
        logic [31:0] w;
        case (m)
            0: begin w = model[d][(idx / 4) % 512]; return (w >> (8 * (idx % 4))) & 32'hFF; end
            1: begin w = model[d][(idx / 2) % 512]; return (w >> (16 * (idx % 2))) & 32'hFFFF; end
            default: return model[d][idx % 512];
        endcase
    endfunction

    // driver: one cycle of stimulus; expectations use pre-cycle state
    task automatic drive(int hwe, int hdir, int hidx, logic [31:0] hdat, int hchk,
                         int mwe, int mval, int c0, int c1, string tag);
        item_t e;
        @(negedge clk); #1;
        host_we    = hwe[0];
        host_dir   = hdir[0];
        host_idx   = 11'(hidx);
        host_wdata = hdat;
        mode_we    = mwe[0];
        mode_wdata = 2'(mval);
        core_idx[0] = 11'(c0 < 0 ? 0 : c0);
        core_idx[1] = 11'(c1 < 0 ? 0 : c1);
        if (c0 >= 0) begin e.kind = 0; e.exp = entry(0, c0, bmode[0]); e.due = cyc + 1; e.tag = tag; sb.push_back(e); end
        if (c1 >= 0) begin e.kind = 1; e.exp = entry(1, c1, bmode[1]); e.due = cyc + 1; e.tag = tag; sb.push_back(e); end
        if (hchk != 0) begin e.kind = 2; e.exp = model[hdir][hidx % 512]; e.due = cyc + 1; e.tag = tag; sb.push_back(e); end
        if (hwe != 0) model[hdir][hidx % 512] = hdat;
        if (mwe != 0) bmode[hdir] = mval;
    endtask

    task automatic idle();
        drive(0, 0, 0, 32'h0, 0, 0, 0, -1, -1, "idle");
    endtask

    task automatic hwrite(int d, int idx, logic [31:0] v);
        drive(1, d, idx, v, 0, 0, 0, -1, -1, "R1");
    endtask

    task automatic setmode(int d, int m);
        drive(0, d, 0, 32'h0, 0, 1, m, -1, -1, "R2");
    endtask

    task automatic check_now(logic [31:0] act, logic [31:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bmode[0] = 0; bmode[1] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        idle();
        check_now(32'(mode_rd[0]), 32'd0, "R2 reset tx mode");
        check_now(32'(mode_rd[1]), 32'd0, "R2 reset rx mode");

        // fill both tables with distinct patterns (R1, R9)
        for (int i = 0; i < 8; i++) begin
            hwrite(0, i, 32'hA0B0C0D0 + 32'(i * 32'h01010101));
            hwrite(1, i, 32'h11223344 ^ 32'(i * 32'h10000001));
        end
        hwrite(0, 511, 32'hDEADBEEF);
        hwrite(0, 600, 32'h0BADF00D);  // R10: lands in word 88
        for (int i = 0; i < 8; i++) drive(0, 0, i, 32'h0, 1, 0, 0, -1, -1, "R1 host readback tx");
        for (int i = 0; i < 8; i++) drive(0, 1, i, 32'h0, 1, 0, 0, -1, -1, "R9 host readback rx");
        drive(0, 0, 88, 32'h0, 1, 0, 0, -1, -1, "R10 host wrap");

        // byte mode on both (reset default) R3
        for (int i = 0; i < 16; i++) drive(0, 0, 0, 32'h0, 0, 0, 0, i, 31 - i, "R3 byte entries");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 2047, -1, "R10 byte top index");

        // halfword mode R4
        setmode(0, 1);
        idle();
        check_now(32'(mode_rd[0]), 32'd1, "R2 readback half");
        check_now(32'(mode_rd[1]), 32'd0, "R9 rx mode untouched");
        for (int i = 0; i < 12; i++) drive(0, 0, 0, 32'h0, 0, 0, 0, i, i, "R4 half entries");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 1023, -1, "R4 half top index");

        // word mode R5, reserved R6
        setmode(0, 2);
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 32'h0, 0, 0, 0, i, i, "R5 word entries");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 600, -1, "R10 word wrap");
        setmode(0, 3);
        idle();
        check_now(32'(mode_rd[0]), 32'd3, "R2 readback reserved");
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 32'h0, 0, 0, 0, i, -1, "R6 reserved as word");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 88, -1, "R6 reserved word 88");

        // mode write with core read in the same cycle: old mode applies (R7)
        drive(0, 0, 0, 32'h0, 0, 1, 0, 5, -1, "R7 read during mode write");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 5, -1, "R7 read after mode write");

        // same-word write and core read (R8), byte mode, word 1 = bytes 4..7
        drive(1, 0, 1, 32'hCAFE1234, 0, 0, 0, 6, -1, "R8 old data on collision");
        drive(0, 0, 0, 32'h0, 0, 0, 0, 6, -1, "R8 new data next read");
        setmode(0, 2);
        drive(1, 0, 3, 32'h5555AAAA, 1, 0, 0, 3, -1, "R8 word collision");
        drive(0, 0, 3, 32'h0, 1, 0, 0, 3, -1, "R8 word after write");

        // rx table unaffected by all tx writes, mode change on rx alone (R9)
        drive(1, 1, 2, 32'h77665544, 0, 0, 0, 1, 1, "R9 rx write vs tx read");
        setmode(1, 1);
        idle();
        check_now(32'(mode_rd[0]), 32'd2, "R9 tx mode untouched");
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 32'h0, 0, 0, 0, i, i, "R9 independent modes");

        repeat (3) idle();
        check_now(32'(sb.size()), 32'd0, "R7 scoreboard drained");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule